// File: doc/BRIEF.md
# Multi-Lane Vector Integer Adder

This block keeps two source vectors and one result vector in internal storage and computes the element-wise sum of the sources into the result. Each vector has 64 elements of 64 bits. The sum is a two's-complement integer addition that wraps around on overflow. The work is spread over four identical add lanes. Element `i` always goes to lane `i mod 4`, so one operation needs 16 issue cycles and retires four sums per cycle once the lanes are full.

Software-side logic fills the sources one element per cycle through a load port. The same port also writes a per-element write-enable mask; a cleared mask bit protects that result element from being overwritten. A one-cycle `start` launches the operation. `busy` stays high while it runs, and `done` pulses for one cycle when the last sums have been written. The result vector can be read at any time through a combinational read port.

Top module: `vadd_lanes`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `busy` and `done` are 0, every result element reads 0, and every mask bit is 1.
- R2: When an operation completes, each result element `i` whose mask bit is 1 equals `(A[i] + B[i]) mod 2^64`.
- R3: During an operation, the results for elements `4g` to `4g+3` all become visible together, `g + 3` clock cycles after the edge that accepted `start`.
- R4: `busy` is high for exactly 18 cycles after an accepted `start`. `done` is high for one cycle and only in the first cycle after `busy` falls.
- R5: `start` is accepted only while `busy` is low, which includes the cycle in which `done` is high. A `start` while `busy` is high has no effect.
- R6: A mask bit of 0 leaves the corresponding result element at its previous value. The mask is written with `ld_sel` = 2: bit 0 of `ld_data` goes to the mask bit of element `ld_idx`.
- R7: Loads while `busy` is high are ignored. Outside a run, `ld_sel` = 0 writes `ld_data` to source A element `ld_idx`, `ld_sel` = 1 writes it to source B, and `ld_sel` = 3 writes nothing. The result vector changes only during an operation.
- R8: `rd_data` shows result element `rd_idx` in the same cycle that `rd_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 = A, 1 = B, 2 = mask, 3 = none |
| ld_idx | input | 6 | Element index for the load |
| ld_data | input | 64 | Load value (only bit 0 is used for the mask) |
| start | input | 1 | Launch an operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Result element to read |
| rd_data | output | 64 | Selected result element |

## Verification
The assertions assume that `start` and the load inputs are stable across each rising edge. They also assume `rd_idx` is a clean value, so that a stable index shows a stable result element while no operation runs. The stimulus meets these assumptions because it changes every input only at the falling edge. It issues `start` during a run and in the `done` cycle on purpose, so that both the ignored and the accepted cases are covered. The operand values include all-ones and sign-boundary values, so wraparound occurs in several lanes.

// File: rtl/vadd_pkg.sv
// Shared definitions for the multi-lane vector adder.
// Assumes: the load selector is 2 bits wide.
package vadd_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } ld_sel_e;

    // Register stages in every lane: operand capture, then sum.
    localparam int unsigned LANE_DEPTH = 2;
endpackage

// File: rtl/vadd_ctrl.sv
// Sequencer for one vector add. It issues one element group per cycle for
// GROUPS cycles, then waits for the lanes to drain, then pulses done.
// Assumes: start is a level that is sampled only while idle.
module vadd_ctrl #(
    parameter int unsigned GROUPS = 16,
    parameter int unsigned DRAIN  = 2,
    localparam int unsigned LAST  = GROUPS + DRAIN - 1,
    localparam int unsigned CW    = $clog2(LAST + 1),
    localparam int unsigned GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          issue_vld,
    output logic [GW-1:0] issue_grp
);
    logic [CW-1:0] cnt_q;

    // Run state: accept start when idle, count the cycles, retire at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    cnt_q <= '0;
                end
            end else if (cnt_q == CW'(LAST)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Issue window: the first GROUPS cycles of a run.
    always_comb begin
        issue_vld = busy && (cnt_q < CW'(GROUPS));
        issue_grp = GW'(cnt_q);
    end
endmodule

// File: rtl/vadd_lane.sv
// One add lane: it registers the operands, then registers the wrapped sum,
// carrying the element index and write-keep flag along with the data.
// Assumes: the sum is written back one stage after out_vld.
module vadd_lane #(
    parameter int unsigned W  = 64,
    parameter int unsigned IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [IW-1:0] in_idx,
    input  logic          in_keep,
    output logic          out_vld,
    output logic [W-1:0]  out_sum,
    output logic [IW-1:0] out_idx,
    output logic          out_keep
);
    logic          s1_vld;
    logic [W-1:0]  s1_a, s1_b;
    logic [IW-1:0] s1_idx;
    logic          s1_keep;

    // Stage 1: operand register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= in_vld;
        end
        s1_a    <= in_a;
        s1_b    <= in_b;
        s1_idx  <= in_idx;
        s1_keep <= in_keep;
    end

    // Stage 2: sum register (modulo 2^W).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= s1_vld;
        end
        out_sum  <= s1_a + s1_b;
        out_idx  <= s1_idx;
        out_keep <= s1_keep;
    end
endmodule

// File: rtl/vadd_regs.sv
// Vector storage: two source vectors, a write mask and the result vector.
// It provides per-lane operand reads, per-lane result writes, a load port
// and a combinational result read port.
// Assumes: the lanes never write the same element in the same cycle.
module vadd_regs
    import vadd_pkg::*;
#(
    parameter int unsigned ELEMS = 64,
    parameter int unsigned W     = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned IW   = $clog2(ELEMS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       ld_en,
    input  logic [1:0]                 ld_sel,
    input  logic [IW-1:0]              ld_idx,
    input  logic [W-1:0]               ld_data,
    input  logic [LANES-1:0][IW-1:0]   op_idx,
    output logic [LANES-1:0][W-1:0]    op_a,
    output logic [LANES-1:0][W-1:0]    op_b,
    output logic [LANES-1:0]           op_keep,
    input  logic [LANES-1:0]           wb_vld,
    input  logic [LANES-1:0]           wb_keep,
    input  logic [LANES-1:0][IW-1:0]   wb_idx,
    input  logic [LANES-1:0][W-1:0]    wb_sum,
    input  logic [IW-1:0]              rd_idx,
    output logic [W-1:0]               rd_data
);
    logic [W-1:0]     a_q [ELEMS];
    logic [W-1:0]     b_q [ELEMS];
    logic [W-1:0]     c_q [ELEMS];
    logic [ELEMS-1:0] mask_q;

    // Source vectors: written by the load port only while idle.
    always_ff @(posedge clk) begin
        if (ld_en && !busy) begin
            if (ld_sel_e'(ld_sel) == SEL_A) a_q[ld_idx] <= ld_data;
            if (ld_sel_e'(ld_sel) == SEL_B) b_q[ld_idx] <= ld_data;
        end
    end

    // Mask: all ones after reset; bit 0 of ld_data is loaded while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (ld_en && !busy && ld_sel_e'(ld_sel) == SEL_MASK) begin
            mask_q[ld_idx] <= ld_data[0];
        end
    end

    // Result vector: cleared by reset, written by lanes whose keep flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ELEMS; e++) c_q[e] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wb_vld[l] && wb_keep[l]) c_q[wb_idx[l]] <= wb_sum[l];
            end
        end
    end

    // Per-lane operand fetch.
    for (genvar l = 0; l < LANES; l++) begin : g_fetch
        assign op_a[l]    = a_q[op_idx[l]];
        assign op_b[l]    = b_q[op_idx[l]];
        assign op_keep[l] = mask_q[op_idx[l]];
    end

    assign rd_data = c_q[rd_idx];
endmodule

// File: rtl/vadd_lanes.sv
// Top of the multi-lane vector adder. Each issue cycle it sends elements
// grp*LANES+l to lane l, so that element i always goes to lane i mod LANES.
// Assumes: ELEMS is a multiple of LANES.
module vadd_lanes
    import vadd_pkg::*;
#(
    parameter int unsigned ELEMS = 64,
    parameter int unsigned W     = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned IW     = $clog2(ELEMS),
    localparam int unsigned GROUPS = ELEMS / LANES,
    localparam int unsigned GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic                     issue_vld;
    logic [GW-1:0]            issue_grp;
    logic [LANES-1:0][IW-1:0] op_idx;
    logic [LANES-1:0][W-1:0]  op_a, op_b;
    logic [LANES-1:0]         op_keep;
    logic [LANES-1:0]         wb_vld, wb_keep;
    logic [LANES-1:0][IW-1:0] wb_idx;
    logic [LANES-1:0][W-1:0]  wb_sum;

    vadd_ctrl #(.GROUPS(GROUPS), .DRAIN(LANE_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .issue_vld(issue_vld), .issue_grp(issue_grp)
    );

    vadd_regs #(.ELEMS(ELEMS), .W(W), .LANES(LANES)) u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
        .op_idx(op_idx), .op_a(op_a), .op_b(op_b), .op_keep(op_keep),
        .wb_vld(wb_vld), .wb_keep(wb_keep), .wb_idx(wb_idx), .wb_sum(wb_sum),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // One lane per element slot of a group.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign op_idx[l] = IW'(issue_grp) * IW'(LANES) + IW'(l);

        vadd_lane #(.W(W), .IW(IW)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .in_vld(issue_vld), .in_a(op_a[l]), .in_b(op_b[l]),
            .in_idx(op_idx[l]), .in_keep(op_keep[l]),
            .out_vld(wb_vld[l]), .out_sum(wb_sum[l]),
            .out_idx(wb_idx[l]), .out_keep(wb_keep[l])
        );
    end
endmodule

// File: rtl/vadd_lanes_chk.sv
// Protocol checker for vadd_lanes. It watches only the ports and counts the
// length of each run with a local counter.
// Assumes: inputs are stable across each rising clock edge.
module vadd_lanes_chk #(
    parameter int unsigned ELEMS = 64,
    parameter int unsigned W     = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned IW   = $clog2(ELEMS),
    localparam int unsigned RUN  = ELEMS / LANES + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [IW-1:0] rd_idx,
    input logic [W-1:0]  rd_data
);
    logic [15:0] run_len;

    // Count the cycles busy has been high in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 16'(RUN)));
    a_r5_idle_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    a_r5_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r7_idle_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && $stable(rd_idx)) |-> $stable(rd_data));
endmodule

bind vadd_lanes vadd_lanes_chk #(.ELEMS(ELEMS), .W(W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/sim_vadd_lanes.sv
`timescale 1ns/1ps
// Bench for vadd_lanes. A behavioural model is updated on each rising edge.
// Outputs are compared 1 ns after every falling edge; inputs change at the
// falling edge.
module sim_vadd_lanes;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = 2'd3;
    logic [5:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit chk_on = 1'b0;
    string ph = "R2";

    // Reference state
    logic [63:0] ma [64];
    logic [63:0] mb [64];
    logic [63:0] mc [64];
    bit          mm [64];
    bit          m_busy = 0, m_done = 0;
    int          m_run = 0;

    always #2.5 clk = ~clk;

    vadd_lanes u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_idx(ld_idx), .ld_data(ld_data), .start(start), .busy(busy),
        .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Model: a run of 16 groups; group g lands g+3 cycles after the start edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_run = 0;
            for (int i = 0; i < 64; i++) begin mc[i] = '0; mm[i] = 1; end
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_run >= 2) begin
                    for (int l = 0; l < 4; l++) begin
                        int e;
                        e = (m_run - 2) * 4 + l;
                        if (mm[e]) mc[e] = ma[e] + mb[e];
                    end
                end
                if (m_run == 17) begin m_busy = 0; m_done = 1; end
                else m_run++;
            end else begin
                if (ld_en) begin
                    case (ld_sel)
                        2'd0: ma[ld_idx] = ld_data;
                        2'd1: mb[ld_idx] = ld_data;
                        2'd2: mm[ld_idx] = ld_data[0];
                        default: ;
                    endcase
                end
                if (start) begin m_busy = 1; m_run = 0; end
            end
        end
    end

    // Step the read index and compare every cycle. rd_idx changes at this
    // falling edge, so each read check also covers the same-cycle read (R8).
    always @(negedge clk) begin
        rd_idx = rd_idx + 6'd7;
        #1;
        if (chk_on) begin
            string rt;
            rt = !rst_n ? "R1" : (m_busy ? "R3" : ph);
            check(busy === m_busy, !rst_n ? "R1 busy" : "R4 busy", 64'(busy), 64'(m_busy));
            check(done === m_done, !rst_n ? "R1 done" : "R4 done", 64'(done), 64'(m_done));
            check(rd_data === mc[rd_idx], {rt, ",R8 rd_data"}, rd_data, mc[rd_idx]);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    task automatic load(input logic [1:0] sel, input int idx, input logic [63:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_idx = 6'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0; ld_sel = 2'd3;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ma[i] = '0; mb[i] = '0; end
        // R1: reset held long enough to read all 64 result elements.
        @(negedge clk);
        chk_on = 1'b1;
        repeat (66) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 operands; the first elements and the sign boundary wrap around.
        for (int i = 0; i < 64; i++) begin
            logic [63:0] a, b;
            if (i < 4)       begin a = '1;                 b = 64'(i + 1); end
            else if (i < 8)  begin a = 64'h8000_0000_0000_0000; b = 64'h8000_0000_0000_0000 + 64'(i); end
            else             begin a = 64'(i) * 64'h0123_4567_89AB_CDEF; b = ~(64'(i) << 20); end
            load(2'd0, i, a);
            load(2'd1, i, b);
        end
        load(2'd3, 5, 64'hDEAD);   // R7: selector 3 writes nothing
        ph = "R2";
        pulse_start();
        repeat (80) @(negedge clk);

        // R5 and R7: repeat start and try a load while busy; neither may act.
        for (int i = 0; i < 64; i++) load(2'd1, i, 64'(i) * 64'h1111);
        ph = "R7";
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        load(2'd0, 0, 64'h5555);
        load(2'd2, 1, 64'h0);
        while (!done) @(negedge clk);
        // R5: a start in the done cycle is accepted.
        ph = "R5";
        pulse_start();
        repeat (70) @(negedge clk);

        // R6: clear the mask for every third element and change B.
        for (int i = 0; i < 64; i++) begin
            if (i % 3 == 0) load(2'd2, i, 64'h0);
            load(2'd1, i, 64'hFFFF_0000_0000_0000 ^ 64'(i * 3));
        end
        ph = "R6";
        pulse_start();
        repeat (90) @(negedge clk);
        finish_run();
    end
endmodule